// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Bank

This block is a small register file addressed over a byte-wide subaddress/data bus, the kind a serial-bus slave front end presents after it has decoded a transfer. Host writes land in shadow registers. The processing logic sees only the active copies. A write to a reserved subaddress is a store command, and it arms a take-over for each of two target domains. The active registers of a domain copy their shadow values only when that domain's frame-sync pulse arrives. The host polls a per-domain pending bit to learn when the copy has happened.

Each frame-sync input is asynchronous to the host clock. It is brought in through a two-flop synchronizer, and the block acts on its rising edge. Per-register attributes set three things: the domain a register belongs to, whether it bypasses the take-over and updates as soon as it is written, and which two registers form a wide value. That value becomes effective only when its lower byte is written. Each domain also has one read-back byte. It is captured from the internal side on every sync edge and needs no store command.

The default configuration has eight registers, numbered 0 to 7. Registers 0 to 3 belong to domain 0 and registers 4 to 7 to domain 1. Register 2 is immediate. Register 6 is the upper byte of the wide pair and register 7 is its lower byte.

Top module: `shadow_bank`

## Requirements
- R1: A write of any byte value to subaddress 0xFE is a store command. It sets the pending bits of both domains, and the written value changes no register.
- R2: A read of subaddress 0xFD returns the pending bit of domain 0 in bit 0 and that of domain 1 in bit 1, with all other bits 0.
- R3: A non-immediate active register changes only when a synchronized rising edge of its own domain's frame-sync arrives while that domain is pending. It then takes the shadow value, and the domain's pending bit clears.
- R4: A frame-sync pulse held high for at least two host clock cycles completes its take-over within three host clock cycles of its rising edge. A pulse clears the pending bit exactly once, however long it stays high.
- R5: On every synchronized frame-sync edge, the read-back input of that domain is captured, whether or not a store is pending. Subaddress 0xF0 reads the capture for domain 0 and 0xF1 reads it for domain 1.
- R6: An immediate register's active value equals the written byte on the clock edge that accepts the write. No store and no sync is needed.
- R7: A write to the upper register of the wide pair changes neither its shadow read-back nor its active value. A later write to the lower register moves both bytes into shadow together.
- R8: Any subaddress that is not a register, 0xFD, 0xFE, 0xF0 or 0xF1 reads as 0x00. A write to it leaves every register unchanged.
- R9: A store command issued while a domain is pending leaves the bit set. The next sync transfers the latest shadow contents.
- R10: After reset, every shadow, active and captured register, and both pending bits, are 0.
- R11: A read of register subaddress i returns the shadow value of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| hostAddr | input | 8 | Subaddress for both reads and writes |
| hostWrEn | input | 1 | Write strobe, one cycle per byte |
| hostWrData | input | 8 | Write data byte |
| hostRdData | output | 8 | Combinational read data for hostAddr |
| frameSync | input | 2 | Asynchronous frame-sync pulse, one per domain |
| rdbkIn | input | 16 | Read-back byte per domain, domain d at bits 8d+7 to 8d |
| activeOut | output | 64 | Active registers, register i at bits 8i+7 to 8i |

## Verification
The bench sweeps writes over all 256 subaddresses and then reads every one of them back. A decoder that aliases high addresses onto registers would show up as nonzero reads or as corrupted shadows. It checks that a sync arriving with nothing pending changes no active value but still refreshes the read-back bytes. A design that ignored the pending bit would copy early, and one that tied the capture to the store would return stale bytes. The wide pair is written one half at a time with a store and sync in between, which exposes a design that lets the upper byte through on its own. A long sync pulse with a second store issued during it shows whether the edge detector fires more than once per pulse, because a level-sensitive design would clear the new pending bit.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int NUM_DOM = 2;
  localparam logic [7:0] ADDR_STATUS = 8'hFD;
  localparam logic [7:0] ADDR_STORE  = 8'hFE;
  localparam logic [7:0] ADDR_RDBK0  = 8'hF0;

  typedef struct packed {
    logic               regWr;     // accepted write to a mapped register
    logic [NUM_DOM-1:0] transfer;  // shadow -> active copy per domain
    logic [NUM_DOM-1:0] capture;   // read-back capture per domain
  } bankStrobes_t;
endpackage

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import shadow_bank_pkg::*;
#(
  parameter int REG_COUNT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         hostAddr,
  input  logic               hostWrEn,
  input  logic [NUM_DOM-1:0] frameSync,
  output bankStrobes_t       strobes,
  output logic [NUM_DOM-1:0] pend
);
  localparam logic [7:0] REG_LIMIT = 8'(REG_COUNT);

  logic storeCmd;
  logic [NUM_DOM-1:0] syncEdge;

  assign storeCmd = hostWrEn && (hostAddr == ADDR_STORE);

  always_comb begin
    strobes.regWr    = hostWrEn && (hostAddr < REG_LIMIT);
    strobes.capture  = syncEdge;
    strobes.transfer = syncEdge & pend;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic meta, stable, prevStable;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        meta       <= 1'b0;
        stable     <= 1'b0;
        prevStable <= 1'b0;
      end else begin
        meta       <= frameSync[d];
        stable     <= meta;
        prevStable <= stable;
      end
    end

    assign syncEdge[d] = stable && !prevStable;

    always_ff @(posedge clk) begin
      if (!rstN)         pend[d] <= 1'b0;
      else if (storeCmd) pend[d] <= 1'b1;
      else if (syncEdge[d]) pend[d] <= 1'b0;
    end

    // R3: a sync edge without a competing store clears pending
    a_r3_pend_clears: assert property (@(posedge clk) disable iff (!rstN)
      syncEdge[d] && !storeCmd |=> !pend[d]);
    // R9: pending is held until a sync edge arrives
    a_r9_pend_holds: assert property (@(posedge clk) disable iff (!rstN)
      pend[d] && !syncEdge[d] |=> pend[d]);
    // R4: one edge per pulse, never two cycles in a row
    a_r4_single_edge: assert property (@(posedge clk) disable iff (!rstN)
      syncEdge[d] |=> !syncEdge[d]);
  end

  // R1: store arms both domains
  a_r1_store_arms: assert property (@(posedge clk) disable iff (!rstN)
    storeCmd |=> (pend == {NUM_DOM{1'b1}}));
  // R8: writes outside the register range never reach the register file
  a_r8_unmapped_ignored: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn && (hostAddr >= REG_LIMIT) |-> !strobes.regWr);
endmodule

// File: rtl/shadow_bank_dp.sv
module shadow_bank_dp
  import shadow_bank_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 8,
  parameter logic [REG_COUNT-1:0] DOMAIN_MAP = 8'b1111_0000,
  parameter logic [REG_COUNT-1:0] IMM_MAP    = 8'b0000_0100,
  parameter int HS_HI = 6,
  parameter int HS_LO = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [7:0]                    hostAddr,
  input  logic [DATA_W-1:0]             hostWrData,
  input  bankStrobes_t                  strobes,
  input  logic [NUM_DOM-1:0]            pend,
  input  logic [NUM_DOM*DATA_W-1:0]     rdbkIn,
  output logic [DATA_W-1:0]             rdData,
  output logic [REG_COUNT*DATA_W-1:0]   activeOut
);
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam logic [7:0] REG_LIMIT = 8'(REG_COUNT);

  logic [DATA_W-1:0] shadow [REG_COUNT];
  logic [DATA_W-1:0] active [REG_COUNT];
  logic [DATA_W-1:0] rdbk   [NUM_DOM];
  logic [DATA_W-1:0] hsHold;
  logic [IDX_W-1:0]  wrIdx;
  logic              hsCommit;

  assign wrIdx    = hostAddr[IDX_W-1:0];
  assign hsCommit = strobes.regWr && (wrIdx == IDX_W'(HS_LO));

  always_ff @(posedge clk) begin
    if (!rstN) hsHold <= '0;
    else if (strobes.regWr && (wrIdx == IDX_W'(HS_HI))) hsHold <= hostWrData;
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    if (i == HS_HI) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rstN) shadow[i] <= '0;
        else if (hsCommit) shadow[i] <= hsHold;
      end
      // R7: an upper-byte write alone leaves the shadow untouched
      a_r7_hi_waits: assert property (@(posedge clk) disable iff (!rstN)
        strobes.regWr && (wrIdx == IDX_W'(HS_HI)) |=> $stable(shadow[i]));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN) shadow[i] <= '0;
        else if (strobes.regWr && (wrIdx == IDX_W'(i))) shadow[i] <= hostWrData;
      end
    end

    if (IMM_MAP[i]) begin : g_imm
      always_ff @(posedge clk) begin
        if (!rstN) active[i] <= '0;
        else if (strobes.regWr && (wrIdx == IDX_W'(i))) active[i] <= hostWrData;
        else if (strobes.transfer[DOMAIN_MAP[i]]) active[i] <= shadow[i];
      end
      // R6: immediate register follows the write on the next edge
      a_r6_imm_update: assert property (@(posedge clk) disable iff (!rstN)
        strobes.regWr && (wrIdx == IDX_W'(i)) |=> active[i] == $past(hostWrData));
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) active[i] <= '0;
        else if (strobes.transfer[DOMAIN_MAP[i]]) active[i] <= shadow[i];
      end
      // R3: no take-over means no change
      a_r3_active_stable: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.transfer[DOMAIN_MAP[i]] |=> $stable(active[i]));
    end

    assign activeOut[i*DATA_W +: DATA_W] = active[i];
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rstN) rdbk[d] <= '0;
      else if (strobes.capture[d]) rdbk[d] <= rdbkIn[d*DATA_W +: DATA_W];
    end
    // R5: read-back byte only moves on a sync edge
    a_r5_capture_only_on_edge: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.capture[d] |=> $stable(rdbk[d]));
  end

  always_comb begin
    rdData = '0;
    if (hostAddr < REG_LIMIT)
      rdData = shadow[wrIdx];
    else if (hostAddr == ADDR_STATUS)
      rdData = {{(DATA_W-NUM_DOM){1'b0}}, pend};
    else begin
      for (int d = 0; d < NUM_DOM; d++)
        if (hostAddr == ADDR_RDBK0 + 8'(d)) rdData = rdbk[d];
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 8,
  parameter logic [REG_COUNT-1:0] DOMAIN_MAP = 8'b1111_0000,
  parameter logic [REG_COUNT-1:0] IMM_MAP    = 8'b0000_0100,
  parameter int HS_HI = 6,
  parameter int HS_LO = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [7:0]                  hostAddr,
  input  logic                        hostWrEn,
  input  logic [DATA_W-1:0]           hostWrData,
  output logic [DATA_W-1:0]           hostRdData,
  input  logic [NUM_DOM-1:0]          frameSync,
  input  logic [NUM_DOM*DATA_W-1:0]   rdbkIn,
  output logic [REG_COUNT*DATA_W-1:0] activeOut
);
  bankStrobes_t       strobes;
  logic [NUM_DOM-1:0] pend;

  shadow_bank_ctrl #(.REG_COUNT(REG_COUNT)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .frameSync(frameSync), .strobes(strobes), .pend(pend)
  );

  shadow_bank_dp #(
    .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .DOMAIN_MAP(DOMAIN_MAP),
    .IMM_MAP(IMM_MAP), .HS_HI(HS_HI), .HS_LO(HS_LO)
  ) i_dp (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .strobes(strobes), .pend(pend), .rdbkIn(rdbkIn), .rdData(hostRdData),
    .activeOut(activeOut)
  );
endmodule

// File: tb/test_shadow_bank.sv
module test_shadow_bank;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic [1:0]  frameSync = '0;
  logic [15:0] rdbkIn = '0;
  logic [63:0] activeOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] shM [8];
  logic [7:0] actM [8];
  logic [7:0] holdM;
  logic [7:0] capM [2];
  logic [1:0] pendM;

  shadow_bank i_shadow_bank (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .frameSync(frameSync),
    .rdbkIn(rdbkIn), .activeOut(activeOut)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int domOf(int i);
    return (i >= 4) ? 1 : 0;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (a < 8) begin
      if (a == 6) holdM = d;
      else if (a == 7) begin shM[7] = d; shM[6] = holdM; end
      else shM[a] = d;
      if (a == 2) actM[2] = d;
    end else if (a == 8'hFE) pendM = 2'b11;
  endtask

  task automatic rdChk(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    hostAddr = a;
    #1;
    chk(tag, hostRdData, exp, $sformatf("read addr %02h", a));
  endtask

  task automatic modelSync(int d);
    capM[d] = rdbkIn[d*8 +: 8];
    if (pendM[d]) begin
      for (int i = 0; i < 8; i++) if (domOf(i) == d) actM[i] = shM[i];
      pendM[d] = 1'b0;
    end
  endtask

  task automatic syncPulse(int d);
    @(negedge clk);
    frameSync[d] = 1'b1;
    repeat (4) @(negedge clk);
    frameSync[d] = 1'b0;
    repeat (4) @(negedge clk);
    modelSync(d);
  endtask

  task automatic checkAll(string tag);
    @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk(tag, activeOut[i*8 +: 8], actM[i], $sformatf("active reg %0d", i));
    for (int i = 0; i < 8; i++) rdChk(8'(i), shM[i], "R11");
    rdChk(8'hFD, {6'b0, pendM}, "R2");
    rdChk(8'hF0, capM[0], "R5");
    rdChk(8'hF1, capM[1], "R5");
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin shM[i] = '0; actM[i] = '0; end
    holdM = '0; capM[0] = '0; capM[1] = '0; pendM = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    checkAll("R10");

    // R8, R11, R6: write every subaddress except the store
    for (int a = 0; a < 256; a++)
      if (a != 8'hFE) wr(8'(a), 8'(a) ^ 8'h5A);
    checkAll("R6");
    for (int a = 0; a < 256; a++) begin
      if (a >= 8 && a != 8'hFD && a != 8'hF0 && a != 8'hF1 && a != 8'hFE)
        rdChk(8'(a), 8'h00, "R8");
    end

    // R5 and R3: sync with nothing pending captures only
    rdbkIn = 16'hC33C;
    syncPulse(0);
    syncPulse(1);
    checkAll("R3");

    // R1: store with arbitrary data arms both domains, changes nothing else
    wr(8'hFE, 8'h77);
    checkAll("R1");

    // R3, R4: domain 0 then domain 1 take over
    rdbkIn = 16'h9966;
    syncPulse(0);
    checkAll("R4");
    syncPulse(1);
    checkAll("R3");

    // R7: upper byte alone has no effect
    wr(8'd6, 8'hAB);
    wr(8'hFE, 8'h00);
    syncPulse(1);
    chk("R7", activeOut[6*8 +: 8], 8'h5C, "active upper byte unchanged");
    checkAll("R7");
    wr(8'd7, 8'hCD);
    wr(8'hFE, 8'h01);
    syncPulse(1);
    chk("R7", activeOut[6*8 +: 8], 8'hAB, "active upper byte after lower");
    checkAll("R7");

    // R9: restore while pending transfers the latest shadow
    wr(8'hFE, 8'h10);
    wr(8'd0, 8'h42);
    wr(8'hFE, 8'h20);
    rdChk(8'hFD, 8'h03, "R9");
    syncPulse(0);
    chk("R9", activeOut[7:0], 8'h42, "active reg 0 latest");
    checkAll("R9");
    syncPulse(1);

    // R4: one long pulse clears pending exactly once
    wr(8'hFE, 8'h33);
    @(negedge clk);
    frameSync[0] = 1'b1;
    repeat (5) @(negedge clk);
    modelSync(0);
    wr(8'd1, 8'h11);
    wr(8'hFE, 8'h44);
    repeat (6) @(negedge clk);
    frameSync[0] = 1'b0;
    repeat (4) @(negedge clk);
    rdChk(8'hFD, 8'h03, "R4");
    chk("R4", activeOut[15:8], 8'h5B, "reg 1 held during long pulse");
    syncPulse(0);
    chk("R4", activeOut[15:8], 8'h11, "reg 1 after next pulse");
    checkAll("R4");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule